// File: doc/BRIEF.md
# Byte Opcode Decoder for a Four-Register 16-bit Machine

This block takes one 8-bit opcode, laid out as `iii rr mmm`, and turns it into the control fields that the execute stage of a small 16-bit machine needs. The machine has four registers. The decoder reports the instruction class, a function code, the register index held in the `rr` field, the kind of operand that `mmm` selects and the register that operand names. It also raises a flag when a 16-bit address or constant of two more bytes follows the opcode, so a fetch unit can step past those bytes.

The group with a top field of `000` is split again by bits 4:3 into four groups: no-operand system operations, jumps, bitwise NOT, and one unassigned group. The code 0FFh would mean storing DX into a constant, which has no meaning. It is not reported as illegal. It is reported as an expansion prefix, so the next byte is handed to a different decoding scheme. Every other code with no meaning raises an illegal flag, and the core is expected to halt on it.

The decode logic is combinational and feeds one register stage. Each result appears on the clock edge that samples the opcode.

Top module: `simple_isa_decoder`

## Requirements
- R1: When `op_valid_i` is sampled high at a rising edge, the fields for the opcode sampled at that same edge appear on the outputs after that edge, and `dec_valid_o` is 1. The outputs then hold until the next edge.
- R2: While `rst_ni` is low, every output is 0.
- R3: When `op_valid_i` is sampled low, `dec_valid_o` and every decoded field are 0 after that edge, whatever the opcode input holds.
- R4: Top field 001, 010, 011, 100 and 101 (OR, AND, CMP, SUB, ADD) with a legal `mmm` gives `class_o`=3 (ALU), `func_o` equal to the top field, and `reg_o` equal to `rr` (00=AX, 01=BX, 10=CX, 11=DX).
- R5: Top field 110 with a legal `mmm` is the load form of move: `class_o`=1 and `reg_o`=`rr`. Top field 111 with `mmm`=110 is the store form: `class_o`=2, `reg_o`=`rr`, `kind_o`=2.
- R6: For `mmm`: codes 000 to 011 give `kind_o`=1 (register) with `opnd_reg_o`=`mmm[1:0]`, 110 gives `kind_o`=2 (direct memory), 111 gives `kind_o`=3 (immediate), and 100 or 101 make the opcode illegal wherever `mmm` names an operand.
- R7: `ext_o` is 1 exactly when the opcode is legal and either its operand kind is memory or immediate, or it is a jump.
- R8: Top field 000 with bits 4:3 = 00 is a system operation: `class_o`=6, `func_o`=`mmm`, legal for `mmm` 000 to 100 only.
- R9: Top field 000 with bits 4:3 = 01 is a jump: `class_o`=5, `func_o`=`mmm`, legal for `mmm` 000 to 110; 111 is illegal.
- R10: Top field 000 with bits 4:3 = 10 is NOT on the `mmm` operand (`class_o`=4). An immediate operand is illegal. Bits 4:3 = 11 is always illegal.
- R11: Opcode 0FFh sets `prefix_o`=1 with `illegal_o`=0 and `ext_o`=0. Any other code with top field 111 and `mmm` other than 110 is illegal.
- R12: On an illegal or prefix result, `class_o`, `func_o`, `reg_o`, `kind_o`, `opnd_reg_o` and `ext_o` are 0, and at most one of `ext_o`, `illegal_o` and `prefix_o` is ever 1. Over all 256 codes, exactly 90 are illegal and 60 set `ext_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode byte present |
| opcode_i | input | 8 | Opcode byte `iii rr mmm` |
| dec_valid_o | output | 1 | Decoded result valid |
| class_o | output | 3 | 0 none, 1 load, 2 store, 3 ALU, 4 NOT, 5 jump, 6 system |
| func_o | output | 3 | ALU operation or jump/system selector |
| reg_o | output | 2 | Register named by `rr` |
| kind_o | output | 2 | Operand kind: 0 none, 1 register, 2 memory, 3 immediate |
| opnd_reg_o | output | 2 | Register named by `mmm` when kind is register |
| ext_o | output | 1 | Two operand bytes follow |
| illegal_o | output | 1 | Unassigned or meaningless opcode |
| prefix_o | output | 1 | Expansion prefix byte (0FFh) |

## Verification
The bench targets the codes at the edges of each nested group. These are the last legal system and jump selectors and the first code past each one, NOT with an immediate operand, the 000 11 group, the unused `mmm` values 100 and 101, stores to a register or a constant, and 0FFh. A decoder that treated 0FFh as a plain illegal store, or let it through as a store, would show the wrong flag. A decoder that let an immediate NOT through, or that treated `mmm`=111 in the jump group as legal, would move the illegal count away from 90 in the full sweep. It would also assert the extension flag in the wrong place and shift the count of 60. Invalid cycles and reset are checked for stale fields left on the outputs.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int unsigned OPC_W = 8;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_STORE = 3'd2,
    CLS_ALU   = 3'd3,
    CLS_NOT   = 3'd4,
    CLS_JUMP  = 3'd5,
    CLS_SYS   = 3'd6
  } cls_e;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_REG  = 2'd1,
    OPK_MEM  = 2'd2,
    OPK_IMM  = 2'd3
  } opk_e;

  typedef struct packed {
    cls_e       cls;
    logic [2:0] func;
    logic [1:0] reg_idx;
    opk_e       kind;
    logic [1:0] opnd_reg;
    logic       ext;
    logic       illegal;
    logic       prefix;
  } dec_t;
endpackage

// File: rtl/sid_operand.sv
module sid_operand
  import sid_pkg::*;
(
  input  logic [2:0] mmm_i,
  output opk_e       kind_o,
  output logic [1:0] opnd_reg_o,
  output logic       bad_o
);
  always_comb begin
    kind_o     = OPK_NONE;
    opnd_reg_o = 2'b00;
    bad_o      = 1'b0;
    if (!mmm_i[2]) begin
      kind_o     = OPK_REG;
      opnd_reg_o = mmm_i[1:0];
    end else if (mmm_i == 3'b110) begin
      kind_o = OPK_MEM;
    end else if (mmm_i == 3'b111) begin
      kind_o = OPK_IMM;
    end else begin
      bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/sid_group.sv
module sid_group
  import sid_pkg::*;
#(
  parameter int unsigned     N_SYS       = 5,
  parameter int unsigned     N_JMP       = 7,
  parameter logic [OPC_W-1:0] PREFIX_CODE = 8'hFF
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  opk_e             kind_i,
  input  logic [1:0]       opnd_reg_i,
  input  logic             opnd_bad_i,
  output dec_t             dec_o
);
  localparam logic [2:0] SYS_LAST = 3'(N_SYS - 1);
  localparam logic [2:0] JMP_LAST = 3'(N_JMP - 1);

  logic [2:0] iii, mmm;
  logic [1:0] rr;
  logic       bad, mem_or_imm;
  dec_t       d;

  assign iii        = opcode_i[7:5];
  assign rr         = opcode_i[4:3];
  assign mmm        = opcode_i[2:0];
  assign mem_or_imm = (kind_i == OPK_MEM) || (kind_i == OPK_IMM);

  always_comb begin
    d   = '0;
    bad = 1'b0;
    case (iii)
      3'b000: begin
        case (rr)
          2'b00: begin
            d.cls  = CLS_SYS;
            d.func = mmm;
            bad    = (mmm > SYS_LAST);
          end
          2'b01: begin
            d.cls  = CLS_JUMP;
            d.func = mmm;
            d.ext  = 1'b1;
            bad    = (mmm > JMP_LAST);
          end
          2'b10: begin
            d.cls      = CLS_NOT;
            d.kind     = kind_i;
            d.opnd_reg = opnd_reg_i;
            d.ext      = (kind_i == OPK_MEM);
            bad        = opnd_bad_i || (kind_i == OPK_IMM);
          end
          default: bad = 1'b1;
        endcase
      end
      3'b110: begin
        d.cls      = CLS_LOAD;
        d.reg_idx  = rr;
        d.kind     = kind_i;
        d.opnd_reg = opnd_reg_i;
        d.ext      = mem_or_imm;
        bad        = opnd_bad_i;
      end
      3'b111: begin
        if (opcode_i == PREFIX_CODE) begin
          d.prefix = 1'b1;
        end else begin
          d.cls     = CLS_STORE;
          d.reg_idx = rr;
          d.kind    = OPK_MEM;
          d.ext     = 1'b1;
          bad       = (kind_i != OPK_MEM);
        end
      end
      default: begin
        d.cls      = CLS_ALU;
        d.func     = iii;
        d.reg_idx  = rr;
        d.kind     = kind_i;
        d.opnd_reg = opnd_reg_i;
        d.ext      = mem_or_imm;
        bad        = opnd_bad_i;
      end
    endcase
    // an illegal code carries no fields
    if (bad) begin
      d         = '0;
      d.illegal = 1'b1;
    end
  end

  assign dec_o = d;
endmodule

// File: rtl/simple_isa_decoder.sv
module simple_isa_decoder
  import sid_pkg::*;
#(
  parameter int unsigned      N_SYS       = 5,
  parameter int unsigned      N_JMP       = 7,
  parameter logic [OPC_W-1:0] PREFIX_CODE = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             dec_valid_o,
  output logic [2:0]       class_o,
  output logic [2:0]       func_o,
  output logic [1:0]       reg_o,
  output logic [1:0]       kind_o,
  output logic [1:0]       opnd_reg_o,
  output logic             ext_o,
  output logic             illegal_o,
  output logic             prefix_o
);
  opk_e       opk;
  logic [1:0] opnd_reg;
  logic       opnd_bad;
  dec_t       dec_d, dec_q;
  logic       vld_q;

  sid_operand i_operand (
    .mmm_i      (opcode_i[2:0]),
    .kind_o     (opk),
    .opnd_reg_o (opnd_reg),
    .bad_o      (opnd_bad)
  );

  sid_group #(
    .N_SYS       (N_SYS),
    .N_JMP       (N_JMP),
    .PREFIX_CODE (PREFIX_CODE)
  ) i_group (
    .opcode_i   (opcode_i),
    .kind_i     (opk),
    .opnd_reg_i (opnd_reg),
    .opnd_bad_i (opnd_bad),
    .dec_o      (dec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dec_q <= '0;
    end else begin
      vld_q <= op_valid_i;
      dec_q <= op_valid_i ? dec_d : '0;
    end
  end

  assign dec_valid_o = vld_q;
  assign class_o     = dec_q.cls;
  assign func_o      = dec_q.func;
  assign reg_o       = dec_q.reg_idx;
  assign kind_o      = dec_q.kind;
  assign opnd_reg_o  = dec_q.opnd_reg;
  assign ext_o       = dec_q.ext;
  assign illegal_o   = dec_q.illegal;
  assign prefix_o    = dec_q.prefix;
endmodule

// File: rtl/sid_checker.sv
module sid_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       op_valid_i,
  input logic [7:0] opcode_i,
  input logic       dec_valid_o,
  input logic [2:0] class_o,
  input logic [2:0] func_o,
  input logic [1:0] reg_o,
  input logic [1:0] kind_o,
  input logic [1:0] opnd_reg_o,
  input logic       ext_o,
  input logic       illegal_o,
  input logic       prefix_o
);
  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (dec_valid_o == $past(op_valid_i)));

  a_r3_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (class_o == 3'd0 && !ext_o && !illegal_o && !prefix_o));

  a_r11_prefix_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefix_o |-> ($past(op_valid_i) && $past(opcode_i) == 8'hFF));

  a_r12_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ext_o, illegal_o, prefix_o}) <= 1);

  a_r12_illegal_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (class_o == 3'd0 && func_o == 3'd0 && reg_o == 2'd0 &&
                   kind_o == 2'd0 && opnd_reg_o == 2'd0));

  a_r7_ext_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_o |-> (kind_o[1] || class_o == 3'd5));
endmodule

bind simple_isa_decoder sid_checker i_sid_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .opcode_i    (opcode_i),
  .dec_valid_o (dec_valid_o),
  .class_o     (class_o),
  .func_o      (func_o),
  .reg_o       (reg_o),
  .kind_o      (kind_o),
  .opnd_reg_o  (opnd_reg_o),
  .ext_o       (ext_o),
  .illegal_o   (illegal_o),
  .prefix_o    (prefix_o)
);

// File: tb/test_simple_isa_decoder.sv
`timescale 1ns/1ps
module test_simple_isa_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic       dec_valid_o, ext_o, illegal_o, prefix_o;
  logic [2:0] class_o, func_o;
  logic [1:0] reg_o, kind_o, opnd_reg_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  simple_isa_decoder i_simple_isa_decoder (
    .clk_i, .rst_ni, .op_valid_i, .opcode_i, .dec_valid_o, .class_o, .func_o,
    .reg_o, .kind_o, .opnd_reg_o, .ext_o, .illegal_o, .prefix_o
  );

  // {opcode, class, func, reg, kind, opnd_reg, ext, illegal, prefix}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {8'hC1, 3'd1, 3'd0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0},  // R5 R6 load AX,BX
    {8'hC6, 3'd1, 3'd0, 2'd0, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0},  // R5 R7 load AX,[mem]
    {8'hFF, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1},  // R11 prefix
    {8'hF6, 3'd2, 3'd0, 2'd2, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0},  // R5 store CX
    {8'hF0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R11 store to reg
    {8'h18, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R10 unassigned group
    {8'h10, 3'd4, 3'd0, 2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0},  // R10 NOT AX
    {8'h16, 3'd4, 3'd0, 2'd0, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0},  // R10 NOT [mem]
    {8'h17, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R10 NOT imm
    {8'h0E, 3'd5, 3'd6, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0},  // R9 last jump
    {8'h0F, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R9 past jumps
    {8'h04, 3'd6, 3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0},  // R8 last system
    {8'h05, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R8 past system
    {8'hAF, 3'd3, 3'd5, 2'd1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0},  // R4 R7 ADD BX,imm
    {8'h3B, 3'd3, 3'd1, 2'd3, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0},  // R4 OR DX,DX
    {8'h6C, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R6 mmm 100
    {8'hD5, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},  // R6 mmm 101
    {8'h7E, 3'd3, 3'd3, 2'd3, 2'd2, 2'd0, 1'b1, 1'b0, 1'b0}   // R4 CMP DX,[mem]
  };

  function automatic logic [14:0] obs();
    return {class_o, func_o, reg_o, kind_o, opnd_reg_o, ext_o, illegal_o, prefix_o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [7:0] op);
    @(negedge clk_i);
    op_valid_i = v;
    opcode_i   = op;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n_ill, n_ext, n_pre;
    op_valid_i = 1'b1;
    opcode_i   = 8'hAF;
    repeat (3) @(posedge clk_i);
    #1;
    check("R2 reset", {17'd0, dec_valid_o, obs()}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    op_valid_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VEC[i][22:15]);
      check($sformatf("R4-table op=%h", VEC[i][22:15]), {17'd0, obs()}, {17'd0, VEC[i][14:0]});
      check("R1 valid", {31'd0, dec_valid_o}, 32'd1);
    end

    // R1: hold until next edge
    apply(1'b1, 8'hC1);
    @(negedge clk_i);
    opcode_i = 8'h18;
    #1;
    check("R1 hold", {17'd0, obs()}, {17'd0, 3'd1, 3'd0, 2'd0, 2'd1, 2'd1, 3'b000});
    @(posedge clk_i);
    #1;
    check("R1 next", {31'd0, illegal_o}, 32'd1);

    // R3: invalid cycle clears fields
    apply(1'b1, 8'hAF);
    apply(1'b0, 8'hFF);
    check("R3 idle", {17'd0, dec_valid_o, obs()}, 32'd0);

    // R12: full sweep
    n_ill = 0; n_ext = 0; n_pre = 0;
    for (int c = 0; c < 256; c++) begin
      apply(1'b1, 8'(c));
      if (illegal_o) n_ill++;
      if (ext_o) n_ext++;
      if (prefix_o) n_pre++;
      if ($countones({ext_o, illegal_o, prefix_o}) > 1)
        check("R12 exclusive", {29'd0, ext_o, illegal_o, prefix_o}, 32'd0);
    end
    check("R12 illegal count", n_ill, 90);
    check("R7 ext count", n_ext, 60);
    check("R11 prefix count", n_pre, 1);

    // R2: reset mid-stream
    apply(1'b1, 8'h7E);
    rst_ni = 1'b0;
    #1;
    check("R2 async reset", {17'd0, dec_valid_o, obs()}, 32'd0);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule